// File: doc/BRIEF.md
# Program-Counter-Based Memory Access Checker

This block guards one protected software module on a small processor. Software loads the module's layout through a narrow write port: a text section, a data section and a protection enable. The text section holds the module's code and the data section holds its private state. While protection is enabled, every bus cycle is judged by combinational logic. The judgement uses where the processor is executing (the current and the previous program counter) and the address the memory bus is touching, and a single violation output is raised for any illegal access.

Code outside the module may enter it only at its first text address. That address serves as the single entry point. Outside code may never read or write the module's sections. The module's own code may read its text, read and write its data, and reach all unprotected memory freely. No code may ever write the text section.

A second address port carries accesses from a DMA master. Any DMA access that lands inside either protected section is flagged, whatever the processor is executing. Besides the combinational violation, a sticky copy is registered and held until reset.

Top module: `pc_access_guard`

## Requirements
- R1: Layout is loaded with `cfg_we` high, and the value takes effect from the next rising clock edge. `cfg_sel` picks the target: 0 selects text start, 1 text end, 2 data start, 3 data end and 4 the control word, whose bit 0 is the protection enable. Reset clears all five to zero, so protection starts disabled.
- R2: While the protection enable is 0, `violation` stays 0 for every combination of bus, program-counter and DMA inputs.
- R3: While the program counter is outside the text section, a bus read or write (`mab_en` high) to the text or data section raises `violation`.
- R4: While the program counter is inside the text section, bus reads and writes to the data section raise no violation.
- R5: A bus write (`mab_wr` high) to the text section raises `violation` even from inside the text section. A read of the text section from inside it does not.
- R6: Bus reads and writes to addresses outside both sections raise no violation, wherever the program counter is.
- R7: A cycle with `prev_pc` outside the text section and `cur_pc` inside it raises `violation` unless `cur_pc` equals the text start, which is the single entry point. Execution that stays inside the text section raises no entry violation.
- R8: A DMA access (`dma_en` high) whose address lies in the text or data section raises `violation` whatever the program counter. DMA accesses elsewhere, and DMA addresses presented with `dma_en` low, do not.
- R9: A section covers start <= address < end on 16-bit byte addresses, so the start address is inside it and the end address is outside it.
- R10: `violation` is combinational in the same cycle as the access. `violation_sticky` becomes 1 at the first rising edge on which `violation` is 1 and stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_we | input | 1 | Layout write strobe |
| cfg_sel | input | 3 | Layout register select (0..4) |
| cfg_wdata | input | 16 | Layout write data |
| cur_pc | input | 16 | Program counter of the current instruction |
| prev_pc | input | 16 | Program counter of the previous instruction |
| mab_addr | input | 16 | Processor memory bus address |
| mab_en | input | 1 | Processor bus access this cycle |
| mab_wr | input | 1 | Processor bus access is a write |
| dma_addr | input | 16 | DMA master address |
| dma_en | input | 1 | DMA access this cycle |
| violation | output | 1 | Combinational illegal-access flag |
| violation_sticky | output | 1 | Registered flag held from the first violation until reset |

## Verification
The hardest situations to reach are the ones where the rules interact at the section edges. Examples are a program counter sitting exactly on the text end while touching data, a jump into the text section one byte past the entry point, and a write to the text section issued by the module's own code. The stimulus first loads the full layout with protection still off, to show the layout alone never trips the flag. It then walks every legal combination while confirming that the sticky flag stays clear. Only after that does it drive the boundary-violating patterns. A mid-run reset then clears the sticky flag and the layout, so the entry-point rule can be checked in isolation.

// File: rtl/guard_pkg.sv
package guard_pkg;

  // Layout register select codes for the configuration port
  typedef enum logic [2:0] {
    SEL_TEXT_LO = 3'd0,
    SEL_TEXT_HI = 3'd1,
    SEL_DATA_LO = 3'd2,
    SEL_DATA_HI = 3'd3,
    SEL_CTRL    = 3'd4
  } cfg_sel_e;

  // Index of each range probe in the comparator array
  typedef enum int {
    PRB_CUR_TEXT  = 0,
    PRB_PREV_TEXT = 1,
    PRB_MAB_TEXT  = 2,
    PRB_MAB_DATA  = 3,
    PRB_DMA_TEXT  = 4,
    PRB_DMA_DATA  = 5
  } probe_e;

  localparam int NUM_PROBES = 6;

endpackage

// File: rtl/guard_range_cmp.sv
module guard_range_cmp #(
  parameter int AW = 16
) (
  input  logic [AW-1:0] addr,
  input  logic [AW-1:0] lo,
  input  logic [AW-1:0] hi,
  output logic          hit
);

  logic above_lo;
  logic below_hi;

  // start inclusive, end exclusive
  always_comb begin
    above_lo = (addr >= lo);
    below_hi = (addr < hi);
    hit      = above_lo & below_hi;
  end

endmodule

// File: rtl/guard_layout_regs.sv
module guard_layout_regs
  import guard_pkg::*;
#(
  parameter int AW    = 16,
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [SEL_W-1:0] sel,
  input  logic [AW-1:0]    wdata,
  output logic [AW-1:0]    text_lo,
  output logic [AW-1:0]    text_hi,
  output logic [AW-1:0]    data_lo,
  output logic [AW-1:0]    data_hi,
  output logic             enable
);

  logic [AW-1:0] text_lo_q, text_lo_d;
  logic [AW-1:0] text_hi_q, text_hi_d;
  logic [AW-1:0] data_lo_q, data_lo_d;
  logic [AW-1:0] data_hi_q, data_hi_d;
  logic          en_q, en_d;
  logic          ld_text_lo, ld_text_hi, ld_data_lo, ld_data_hi, ld_ctrl;

  // decode of the write select into per-register load enables
  always_comb begin
    ld_text_lo = we && (sel == SEL_W'(SEL_TEXT_LO));
    ld_text_hi = we && (sel == SEL_W'(SEL_TEXT_HI));
    ld_data_lo = we && (sel == SEL_W'(SEL_DATA_LO));
    ld_data_hi = we && (sel == SEL_W'(SEL_DATA_HI));
    ld_ctrl    = we && (sel == SEL_W'(SEL_CTRL));
  end

  // next-state
  always_comb begin
    text_lo_d = text_lo_q;
    text_hi_d = text_hi_q;
    data_lo_d = data_lo_q;
    data_hi_d = data_hi_q;
    en_d      = en_q;
    if (ld_text_lo) text_lo_d = wdata;
    if (ld_text_hi) text_hi_d = wdata;
    if (ld_data_lo) data_lo_d = wdata;
    if (ld_data_hi) data_hi_d = wdata;
    if (ld_ctrl)    en_d      = wdata[0];
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      text_lo_q <= '0;
      text_hi_q <= '0;
      data_lo_q <= '0;
      data_hi_q <= '0;
      en_q      <= 1'b0;
    end else begin
      text_lo_q <= text_lo_d;
      text_hi_q <= text_hi_d;
      data_lo_q <= data_lo_d;
      data_hi_q <= data_hi_d;
      en_q      <= en_d;
    end
  end

  assign text_lo = text_lo_q;
  assign text_hi = text_hi_q;
  assign data_lo = data_lo_q;
  assign data_hi = data_hi_q;
  assign enable  = en_q;

  // R1: a write lands in the selected register one edge later
  a_r1_text_lo_load: assert property (@(posedge clk) disable iff (!rst_n)
    (we && sel == SEL_W'(SEL_TEXT_LO)) |=> (text_lo == $past(wdata)));

  a_r1_data_hi_load: assert property (@(posedge clk) disable iff (!rst_n)
    (we && sel == SEL_W'(SEL_DATA_HI)) |=> (data_hi == $past(wdata)));

  // R1: without a write strobe the layout holds
  a_r1_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> ($stable(text_lo) && $stable(text_hi) && $stable(data_lo)
             && $stable(data_hi) && $stable(enable)));

endmodule

// File: rtl/guard_rule_eval.sv
module guard_rule_eval (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic cur_in_text,
  input  logic prev_in_text,
  input  logic cur_at_entry,
  input  logic mab_en,
  input  logic mab_wr,
  input  logic mab_in_text,
  input  logic mab_in_data,
  input  logic dma_en,
  input  logic dma_in_text,
  input  logic dma_in_data,
  output logic violation
);

  logic bad_data_access;
  logic bad_text_write;
  logic bad_text_read;
  logic bad_entry;
  logic bad_dma;
  logic any_bad;

  always_comb begin
    // outside code touching private data
    bad_data_access = mab_en && mab_in_data && !cur_in_text;
    // text is never writable
    bad_text_write  = mab_en && mab_wr && mab_in_text;
    // text readable only from within
    bad_text_read   = mab_en && !mab_wr && mab_in_text && !cur_in_text;
    // jump into the module anywhere but its entry point
    bad_entry       = cur_in_text && !prev_in_text && !cur_at_entry;
    // DMA may never reach protected sections
    bad_dma         = dma_en && (dma_in_text || dma_in_data);
    any_bad         = bad_data_access | bad_text_write | bad_text_read
                    | bad_entry | bad_dma;
    violation       = enable && any_bad;
  end

  // R8: DMA into a protected section is always flagged
  a_r8_dma_flagged: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && dma_en && (dma_in_text || dma_in_data)) |-> violation);

  // R5: a text write is flagged even from inside the module
  a_r5_text_write: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && mab_en && mab_wr && mab_in_text && cur_in_text) |-> violation);

  // R4: module code working on its own data, entered legally, is clean
  a_r4_inside_data_ok: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_in_text && prev_in_text && mab_en && mab_in_data && !mab_in_text
     && !(dma_en && (dma_in_text || dma_in_data))) |-> !violation);

endmodule

// File: rtl/pc_access_guard.sv
module pc_access_guard
  import guard_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int SEL_W  = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [SEL_W-1:0]  cfg_sel,
  input  logic [ADDR_W-1:0] cfg_wdata,
  input  logic [ADDR_W-1:0] cur_pc,
  input  logic [ADDR_W-1:0] prev_pc,
  input  logic [ADDR_W-1:0] mab_addr,
  input  logic              mab_en,
  input  logic              mab_wr,
  input  logic [ADDR_W-1:0] dma_addr,
  input  logic              dma_en,
  output logic              violation,
  output logic              violation_sticky
);

  // ---------------- reset: async assert, sync release ----------------
  logic [SYNC_STAGES-1:0] rst_sync_q;
  logic                   rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[SYNC_STAGES-1];

  // ---------------- layout registers ----------------
  logic [ADDR_W-1:0] text_lo, text_hi, data_lo, data_hi;
  logic              prot_en;

  guard_layout_regs #(.AW(ADDR_W), .SEL_W(SEL_W)) u_layout (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .we      (cfg_we),
    .sel     (cfg_sel),
    .wdata   (cfg_wdata),
    .text_lo (text_lo),
    .text_hi (text_hi),
    .data_lo (data_lo),
    .data_hi (data_hi),
    .enable  (prot_en)
  );

  // ---------------- range comparators ----------------
  logic [ADDR_W-1:0]     probe_addr [NUM_PROBES];
  logic [ADDR_W-1:0]     probe_lo   [NUM_PROBES];
  logic [ADDR_W-1:0]     probe_hi   [NUM_PROBES];
  logic [NUM_PROBES-1:0] probe_hit;

  always_comb begin
    probe_addr[PRB_CUR_TEXT]  = cur_pc;
    probe_addr[PRB_PREV_TEXT] = prev_pc;
    probe_addr[PRB_MAB_TEXT]  = mab_addr;
    probe_addr[PRB_MAB_DATA]  = mab_addr;
    probe_addr[PRB_DMA_TEXT]  = dma_addr;
    probe_addr[PRB_DMA_DATA]  = dma_addr;
  end

  for (genvar p = 0; p < NUM_PROBES; p++) begin : g_probe
    localparam bit IS_DATA = (p == PRB_MAB_DATA) || (p == PRB_DMA_DATA);
    if (IS_DATA) begin : g_data
      always_comb begin
        probe_lo[p] = data_lo;
        probe_hi[p] = data_hi;
      end
    end else begin : g_text
      always_comb begin
        probe_lo[p] = text_lo;
        probe_hi[p] = text_hi;
      end
    end
    guard_range_cmp #(.AW(ADDR_W)) u_cmp (
      .addr (probe_addr[p]),
      .lo   (probe_lo[p]),
      .hi   (probe_hi[p]),
      .hit  (probe_hit[p])
    );
  end

  logic cur_at_entry;
  assign cur_at_entry = (cur_pc == text_lo);

  // ---------------- access rules ----------------
  logic viol_comb;

  guard_rule_eval u_rules (
    .clk          (clk),
    .rst_n        (rst_int_n),
    .enable       (prot_en),
    .cur_in_text  (probe_hit[PRB_CUR_TEXT]),
    .prev_in_text (probe_hit[PRB_PREV_TEXT]),
    .cur_at_entry (cur_at_entry),
    .mab_en       (mab_en),
    .mab_wr       (mab_wr),
    .mab_in_text  (probe_hit[PRB_MAB_TEXT]),
    .mab_in_data  (probe_hit[PRB_MAB_DATA]),
    .dma_en       (dma_en),
    .dma_in_text  (probe_hit[PRB_DMA_TEXT]),
    .dma_in_data  (probe_hit[PRB_DMA_DATA]),
    .violation    (viol_comb)
  );

  assign violation = viol_comb;

  // ---------------- sticky flag ----------------
  logic sticky_q, sticky_d, sticky_ce;

  always_comb begin
    sticky_ce = viol_comb && !sticky_q;
    sticky_d  = sticky_q;
    if (sticky_ce) sticky_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) sticky_q <= 1'b0;
    else            sticky_q <= sticky_d;
  end

  assign violation_sticky = sticky_q;

  // R2: protection off means no violation
  a_r2_off_silent: assert property (@(posedge clk) disable iff (!rst_int_n)
    !prot_en |-> !violation);

  // R10: sticky flag sets after a violation and never drops
  a_r10_sticky_sets: assert property (@(posedge clk) disable iff (!rst_int_n)
    violation |=> violation_sticky);

  a_r10_sticky_holds: assert property (@(posedge clk) disable iff (!rst_int_n)
    violation_sticky |=> violation_sticky);

  // R3: outside code reading data is flagged
  a_r3_outside_data: assert property (@(posedge clk) disable iff (!rst_int_n)
    (prot_en && mab_en && probe_hit[PRB_MAB_DATA] && !probe_hit[PRB_CUR_TEXT])
      |-> violation);

endmodule

// File: tb/tb_pc_access_guard.sv
module tb_pc_access_guard;

  logic        clk;
  logic        rst_n;
  logic        cfg_we;
  logic [2:0]  cfg_sel;
  logic [15:0] cfg_wdata;
  logic [15:0] cur_pc, prev_pc, mab_addr, dma_addr;
  logic        mab_en, mab_wr, dma_en;
  logic        violation, violation_sticky;

  int checks = 0;
  int errors = 0;

  // bench-side model state
  int m_tlo, m_thi, m_dlo, m_dhi;
  bit m_en;
  bit m_sticky;

  pc_access_guard dut (
    .clk              (clk),
    .rst_n            (rst_n),
    .cfg_we           (cfg_we),
    .cfg_sel          (cfg_sel),
    .cfg_wdata        (cfg_wdata),
    .cur_pc           (cur_pc),
    .prev_pc          (prev_pc),
    .mab_addr         (mab_addr),
    .mab_en           (mab_en),
    .mab_wr           (mab_wr),
    .dma_addr         (dma_addr),
    .dma_en           (dma_en),
    .violation        (violation),
    .violation_sticky (violation_sticky)
  );

  // 50 MHz
  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic bit inside_sec(int a, int lo, int hi);
    return (a >= lo) && (a < hi);
  endfunction

  function automatic bit model_viol();
    int  pc, ppc, ma, da;
    bit  pin, ppin, v;
    pc  = int'(cur_pc);
    ppc = int'(prev_pc);
    ma  = int'(mab_addr);
    da  = int'(dma_addr);
    if (!m_en) return 1'b0;
    pin  = inside_sec(pc, m_tlo, m_thi);
    ppin = inside_sec(ppc, m_tlo, m_thi);
    v = 1'b0;
    if (dma_en && (inside_sec(da, m_tlo, m_thi) || inside_sec(da, m_dlo, m_dhi))) v = 1'b1;
    if (mab_en) begin
      if (inside_sec(ma, m_dlo, m_dhi) && !pin) v = 1'b1;
      if (inside_sec(ma, m_tlo, m_thi) && (mab_wr || !pin)) v = 1'b1;
    end
    if (pin && !ppin && pc != m_tlo) v = 1'b1;
    return v;
  endfunction

  task automatic check_bit(string tag, string what, logic got, logic exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got %b expected %b", tag, what, got, exp);
    end
  endtask

  task automatic check_outputs(string tag);
    check_bit(tag, "violation", violation, model_viol());
    check_bit("R10", "violation_sticky", violation_sticky, m_sticky);
  endtask

  task automatic idle_inputs();
    cfg_we = 1'b0; cfg_sel = '0; cfg_wdata = '0;
    cur_pc = 16'h0000; prev_pc = 16'h0000;
    mab_addr = 16'h0000; mab_en = 1'b0; mab_wr = 1'b0;
    dma_addr = 16'h0000; dma_en = 1'b0;
  endtask

  task automatic end_cycle();
    bit ev;
    ev = model_viol();
    @(posedge clk);
    #1;
    if (ev) m_sticky = 1'b1;
  endtask

  task automatic cfg_write(string tag, int sel, int val);
    @(negedge clk);
    idle_inputs();
    cfg_we = 1'b1; cfg_sel = 3'(sel); cfg_wdata = 16'(val);
    #2;
    check_outputs(tag);
    end_cycle();
    case (sel)
      0: m_tlo = val;
      1: m_thi = val;
      2: m_dlo = val;
      3: m_dhi = val;
      4: m_en  = val[0];
      default: ;
    endcase
  endtask

  task automatic bus(string tag, int pc, int ppc, int ma, bit men, bit mwr, int da, bit den);
    @(negedge clk);
    idle_inputs();
    cur_pc = 16'(pc); prev_pc = 16'(ppc);
    mab_addr = 16'(ma); mab_en = men; mab_wr = mwr;
    dma_addr = 16'(da); dma_en = den;
    #2;
    check_outputs(tag);
    end_cycle();
  endtask

  task automatic do_reset();
    @(negedge clk);
    idle_inputs();
    rst_n = 1'b0;
    m_tlo = 0; m_thi = 0; m_dlo = 0; m_dhi = 0; m_en = 1'b0; m_sticky = 1'b0;
    #2;
    check_outputs("R1");
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #2;
    check_outputs("R1");
  endtask

  task automatic load_layout();
    cfg_write("R1", 0, 16'h8000);
    cfg_write("R1", 1, 16'h8100);
    cfg_write("R1", 2, 16'h0200);
    cfg_write("R1", 3, 16'h0280);
  endtask

  // watchdog
  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    idle_inputs();
    rst_n = 1'b0;
    m_tlo = 0; m_thi = 0; m_dlo = 0; m_dhi = 0; m_en = 1'b0; m_sticky = 1'b0;
    do_reset();

    // R2: layout loaded, protection off, illegal patterns stay quiet
    load_layout();
    bus("R2", 16'h4000, 16'h3ffe, 16'h0210, 1, 1, 16'h8004, 1);
    bus("R2", 16'h8042, 16'h4000, 16'h8010, 1, 1, 16'h0200, 1);

    cfg_write("R1", 4, 1);

    // legal traffic, sticky must stay clear
    bus("R7", 16'h8000, 16'h4000, 16'h0000, 0, 0, 16'h0000, 0); // entry at start
    bus("R4", 16'h8002, 16'h8000, 16'h0210, 1, 0, 16'h0000, 0); // data read
    bus("R4", 16'h8004, 16'h8002, 16'h027e, 1, 1, 16'h0000, 0); // data write
    bus("R5", 16'h8006, 16'h8004, 16'h8080, 1, 0, 16'h0000, 0); // text read inside
    bus("R6", 16'h8008, 16'h8006, 16'h1234, 1, 1, 16'h0000, 0); // inside to open mem
    bus("R6", 16'h4000, 16'h3ffe, 16'h5000, 1, 1, 16'h0000, 0); // outside to open mem
    bus("R9", 16'h4002, 16'h4000, 16'h0280, 1, 0, 16'h0000, 0); // data end excluded
    bus("R9", 16'h4004, 16'h4002, 16'h01ff, 1, 1, 16'h0000, 0); // below data start
    bus("R9", 16'h4006, 16'h4004, 16'h8100, 1, 1, 16'h0000, 0); // text end excluded
    bus("R8", 16'h4008, 16'h4006, 16'h0000, 0, 0, 16'h8100, 1); // dma at text end
    bus("R8", 16'h400a, 16'h4008, 16'h0000, 0, 0, 16'h0210, 0); // dma addr, en low
    bus("R8", 16'h400c, 16'h400a, 16'h0000, 0, 0, 16'h0600, 1); // dma elsewhere
    bus("R9", 16'h8100, 16'h80fe, 16'h0000, 0, 0, 16'h0000, 0); // leaving text

    // violations
    bus("R3", 16'h4000, 16'h3ffe, 16'h0200, 1, 0, 16'h0000, 0); // data start from out
    bus("R3", 16'h4002, 16'h4000, 16'h8000, 1, 0, 16'h0000, 0); // text read from out
    bus("R3", 16'h4004, 16'h4002, 16'h027f, 1, 1, 16'h0000, 0); // data write from out
    bus("R5", 16'h8010, 16'h800e, 16'h8020, 1, 1, 16'h0000, 0); // text write inside
    bus("R9", 16'h8100, 16'h80fe, 16'h0210, 1, 0, 16'h0000, 0); // pc at text end
    bus("R8", 16'h8010, 16'h800e, 16'h0000, 0, 0, 16'h80ff, 1); // dma into text
    bus("R8", 16'h4000, 16'h3ffe, 16'h0000, 0, 0, 16'h0200, 1); // dma into data
    bus("R10", 16'h4000, 16'h3ffe, 16'h5000, 1, 0, 16'h0000, 0); // sticky held

    // R10: reset clears sticky, then the entry rule alone
    do_reset();
    load_layout();
    cfg_write("R1", 4, 1);
    bus("R7", 16'h8010, 16'h800e, 16'h0000, 0, 0, 16'h0000, 0); // stays inside
    bus("R7", 16'h8001, 16'h4000, 16'h0000, 0, 0, 16'h0000, 0); // bad entry
    bus("R7", 16'h80ff, 16'h7fff, 16'h0000, 0, 0, 16'h0000, 0); // bad entry at end-1

    // R2: disabling again silences everything
    cfg_write("R2", 4, 0);
    bus("R2", 16'h8001, 16'h4000, 16'h8010, 1, 1, 16'h0210, 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule